// File: doc/BRIEF.md
# Time-Shared Nine/Seven-Bit Substitution Engine

This block evaluates two fixed nonlinear substitution functions of a 64-bit Feistel cipher: a 9-bit to 9-bit box and a 7-bit to 7-bit box. Both run on one combinational network. The 7-bit operand is padded with two zero bits at the top so that it fits the 9-bit datapath. Every two-input AND product that either box needs is built once and shared by both sets of output equations. The block works on one box per step. An internal phase bit decides which operand goes through the network and which result register captures the answer.

A surrounding round controller drives a single step strobe. On each strobed cycle the block substitutes the operand for the current phase, loads the result register for that phase, and moves to the other phase. The two result registers are separate outputs, so the controller can read a 9-bit result while the 7-bit result from the previous step stays in place. A one-cycle update flag marks which register was just written. The reset input asserts asynchronously and is released through a short synchronizer.

Top module: `sbox_duo`

## Requirements
- R1: While reset is active, and after it is released, `phase_o` is 0 (the 9-bit phase), both result registers read zero and both update flags are low.
- R2: When `step_i` is high in the 9-bit phase, the next clock edge loads `s9_q_o` with the substitution of `op9_i`, pulses `s9_upd_o` for one cycle and sets `phase_o` to 1.
- R3: When `step_i` is high in the 7-bit phase (`phase_o` = 1), the next clock edge loads `s7_q_o` with the substitution of `op7_i`, pulses `s7_upd_o` for one cycle and sets `phase_o` to 0.
- R4: A step in one phase leaves the result register of the other phase unchanged.
- R5: While `step_i` is low, `phase_o`, `s9_q_o` and `s7_q_o` keep their values and both update flags are low.
- R6: The operand of the inactive phase has no effect on any output: `op7_i` is ignored during a 9-bit step and `op9_i` is ignored during a 7-bit step.
- R7: At most one update flag is high in any cycle.
- R8: The 9-bit mapping matches the cipher's 9-bit box for all 512 inputs, with bit 0 as the LSB. For example, inputs 0, 1, 2, 3 and 4 map to 451, 203, 339, 415 and 483.
- R9: The 7-bit mapping matches the cipher's 7-bit box for all 128 inputs, with bit 0 as the LSB. For example, inputs 0 to 6 map to 27, 50, 51, 90, 59, 16 and 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Substitute the current phase's operand and advance the phase |
| op9_i | input | 9 | Operand for the 9-bit box |
| op7_i | input | 7 | Operand for the 7-bit box |
| phase_o | output | 1 | Current phase: 0 for the 9-bit box, 1 for the 7-bit box |
| s9_q_o | output | 9 | Registered 9-bit substitution result |
| s7_q_o | output | 7 | Registered 7-bit substitution result |
| s9_upd_o | output | 1 | High for one cycle after `s9_q_o` was loaded |
| s7_upd_o | output | 1 | High for one cycle after `s7_q_o` was loaded |

## Verification
A stuck or inverted phase bit shows up at the first strobed cycle. The wrong register loads, the wrong update flag rises, and `phase_o` fails to alternate, all visible one edge after the strobe. A wrong shared product term corrupts output bits in both boxes, but only for operands that set both of its input bits. That is why every input value of each box is swept, while the operand of the idle phase carries deliberately different data. Leaks between the two operand paths then appear as wrong results at the next edge.

// File: rtl/subst_pkg.sv
package subst_pkg;
  localparam int WIDE_W   = 9;
  localparam int NARROW_W = 7;
  localparam int PAD_W    = WIDE_W - NARROW_W;
  localparam int PAIR_N   = WIDE_W * (WIDE_W - 1) / 2;

  typedef enum logic {PH_WIDE = 1'b0, PH_NARROW = 1'b1} phase_e;

  // flat index of the product of bits a and b, a < b
  function automatic int pair_idx(input int a, input int b);
    return a * WIDE_W - (a * (a + 1)) / 2 + (b - a - 1);
  endfunction
endpackage

// File: rtl/subst_rst_sync.sv
module subst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_sync_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_sync_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/subst_operand_mux.sv
module subst_operand_mux
  import subst_pkg::*;
(
  input  phase_e              phase_i,
  input  logic [WIDE_W-1:0]   op9_i,
  input  logic [NARROW_W-1:0] op7_i,
  output logic [WIDE_W-1:0]   w_o
);
  logic [WIDE_W-1:0] narrow_ext;

  assign narrow_ext = {{PAD_W{1'b0}}, op7_i};

  always_comb begin
    w_o = (phase_i == PH_NARROW) ? narrow_ext : op9_i;
  end
endmodule

// File: rtl/subst_term_gen.sv
module subst_term_gen
  import subst_pkg::*;
(
  input  logic [WIDE_W-1:0] w_i,
  output logic [PAIR_N-1:0] prod_o
);
  for (genvar ga = 0; ga < WIDE_W; ga++) begin : g_row
    for (genvar gb = ga + 1; gb < WIDE_W; gb++) begin : g_col
      assign prod_o[pair_idx(ga, gb)] = w_i[ga] & w_i[gb];
    end
  end
endmodule

// File: rtl/subst_xor_net.sv
module subst_xor_net
  import subst_pkg::*;
(
  input  phase_e              phase_i,
  input  logic [WIDE_W-1:0]   w_i,
  input  logic [PAIR_N-1:0]   prod_i,
  output logic [WIDE_W-1:0]   res_o
);
  logic [WIDE_W-1:0]   x;
  logic [WIDE_W-1:0]   r9;
  logic [NARROW_W-1:0] r7;

  function automatic logic p(input logic [PAIR_N-1:0] v, input int a, input int b);
    return v[pair_idx(a, b)];
  endfunction

  assign x = w_i;

  always_comb begin
    r9[0] = p(prod_i,0,4) ^ p(prod_i,0,5) ^ p(prod_i,1,5) ^ p(prod_i,1,6) ^ p(prod_i,2,6)
          ^ p(prod_i,2,7) ^ p(prod_i,3,7) ^ p(prod_i,3,8) ^ p(prod_i,4,8) ^ 1'b1;
    r9[1] = p(prod_i,0,2) ^ x[3] ^ p(prod_i,1,3) ^ p(prod_i,2,3) ^ p(prod_i,3,4)
          ^ p(prod_i,4,5) ^ p(prod_i,0,6) ^ p(prod_i,2,6) ^ x[7] ^ p(prod_i,0,8)
          ^ p(prod_i,3,8) ^ p(prod_i,5,8) ^ 1'b1;
    r9[2] = p(prod_i,0,1) ^ p(prod_i,1,3) ^ x[4] ^ p(prod_i,0,4) ^ p(prod_i,2,4)
          ^ p(prod_i,3,4) ^ p(prod_i,4,5) ^ p(prod_i,0,6) ^ p(prod_i,5,6) ^ p(prod_i,1,7)
          ^ p(prod_i,3,7) ^ x[8];
    r9[3] = x[0] ^ p(prod_i,1,2) ^ p(prod_i,2,4) ^ x[5] ^ p(prod_i,1,5) ^ p(prod_i,3,5)
          ^ p(prod_i,4,5) ^ p(prod_i,5,6) ^ p(prod_i,1,7) ^ p(prod_i,6,7) ^ p(prod_i,2,8)
          ^ p(prod_i,4,8);
    r9[4] = x[1] ^ p(prod_i,0,3) ^ p(prod_i,2,3) ^ p(prod_i,0,5) ^ p(prod_i,3,5) ^ x[6]
          ^ p(prod_i,2,6) ^ p(prod_i,4,6) ^ p(prod_i,5,6) ^ p(prod_i,6,7) ^ p(prod_i,2,8)
          ^ p(prod_i,7,8);
    r9[5] = x[2] ^ p(prod_i,0,3) ^ p(prod_i,1,4) ^ p(prod_i,3,4) ^ p(prod_i,1,6)
          ^ p(prod_i,4,6) ^ x[7] ^ p(prod_i,3,7) ^ p(prod_i,5,7) ^ p(prod_i,6,7)
          ^ p(prod_i,0,8) ^ p(prod_i,7,8);
    r9[6] = p(prod_i,0,1) ^ x[3] ^ p(prod_i,1,4) ^ p(prod_i,2,5) ^ p(prod_i,4,5)
          ^ p(prod_i,2,7) ^ p(prod_i,5,7) ^ x[8] ^ p(prod_i,0,8) ^ p(prod_i,4,8)
          ^ p(prod_i,6,8) ^ p(prod_i,7,8) ^ 1'b1;
    r9[7] = x[1] ^ p(prod_i,0,1) ^ p(prod_i,1,2) ^ p(prod_i,2,3) ^ p(prod_i,0,4) ^ x[5]
          ^ p(prod_i,1,6) ^ p(prod_i,3,6) ^ p(prod_i,0,7) ^ p(prod_i,4,7) ^ p(prod_i,6,7)
          ^ p(prod_i,1,8) ^ 1'b1;
    r9[8] = x[0] ^ p(prod_i,0,1) ^ p(prod_i,1,2) ^ x[4] ^ p(prod_i,0,5) ^ p(prod_i,2,5)
          ^ p(prod_i,3,6) ^ p(prod_i,5,6) ^ p(prod_i,0,7) ^ p(prod_i,0,8) ^ p(prod_i,3,8)
          ^ p(prod_i,6,8) ^ 1'b1;
  end

  // second AND level: shared pair product gated by one more operand bit
  always_comb begin
    r7[0] = x[0] ^ p(prod_i,1,3) ^ (x[0] & p(prod_i,3,4)) ^ p(prod_i,1,5)
          ^ (x[0] & p(prod_i,2,5)) ^ p(prod_i,4,5) ^ (x[0] & p(prod_i,1,6)) ^ p(prod_i,2,6)
          ^ (x[0] & p(prod_i,5,6)) ^ (x[3] & p(prod_i,5,6)) ^ 1'b1;
    r7[1] = p(prod_i,0,2) ^ p(prod_i,0,4) ^ p(prod_i,3,4) ^ p(prod_i,1,5)
          ^ (x[2] & p(prod_i,4,5)) ^ x[6] ^ p(prod_i,0,6) ^ p(prod_i,3,6)
          ^ (x[2] & p(prod_i,3,6)) ^ (x[1] & p(prod_i,4,6)) ^ (x[0] & p(prod_i,5,6)) ^ 1'b1;
    r7[2] = p(prod_i,1,2) ^ (x[0] & p(prod_i,2,3)) ^ x[4] ^ p(prod_i,1,4)
          ^ (x[0] & p(prod_i,1,4)) ^ p(prod_i,0,5) ^ (x[0] & p(prod_i,4,5)) ^ p(prod_i,3,5)
          ^ (x[1] & p(prod_i,3,5)) ^ x[6] ^ (x[0] & p(prod_i,2,6)) ^ p(prod_i,1,6)
          ^ (x[4] & p(prod_i,5,6));
    r7[3] = x[0] ^ x[1] ^ (x[0] & p(prod_i,1,2)) ^ p(prod_i,0,3) ^ p(prod_i,2,4)
          ^ (x[1] & p(prod_i,4,5)) ^ p(prod_i,2,6) ^ (x[1] & p(prod_i,3,6))
          ^ (x[0] & p(prod_i,4,6)) ^ p(prod_i,5,6) ^ 1'b1;
    r7[4] = p(prod_i,2,3) ^ p(prod_i,0,4) ^ (x[1] & p(prod_i,3,4)) ^ x[5] ^ p(prod_i,2,5)
          ^ (x[1] & p(prod_i,2,5)) ^ (x[0] & p(prod_i,3,5)) ^ p(prod_i,1,6)
          ^ (x[1] & p(prod_i,5,6)) ^ (x[4] & p(prod_i,5,6)) ^ 1'b1;
    r7[5] = x[0] ^ x[1] ^ x[2] ^ (x[0] & p(prod_i,1,2)) ^ p(prod_i,0,3)
          ^ (x[1] & p(prod_i,2,3)) ^ p(prod_i,1,4) ^ (x[0] & p(prod_i,2,4)) ^ p(prod_i,0,5)
          ^ (x[0] & p(prod_i,1,5)) ^ p(prod_i,3,5) ^ p(prod_i,0,6) ^ (x[2] & p(prod_i,5,6));
    r7[6] = p(prod_i,0,1) ^ x[3] ^ p(prod_i,0,3) ^ (x[2] & p(prod_i,3,4)) ^ p(prod_i,0,5)
          ^ p(prod_i,2,5) ^ p(prod_i,3,5) ^ (x[1] & p(prod_i,3,5)) ^ p(prod_i,1,6)
          ^ (x[1] & p(prod_i,2,6)) ^ (x[0] & p(prod_i,3,6)) ^ p(prod_i,4,6)
          ^ (x[2] & p(prod_i,5,6));
  end

  always_comb begin
    res_o = (phase_i == PH_NARROW) ? {{PAD_W{1'b0}}, r7} : r9;
  end
endmodule

// File: rtl/sbox_duo.sv
module sbox_duo
  import subst_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic                step_i,
  input  logic [WIDE_W-1:0]   op9_i,
  input  logic [NARROW_W-1:0] op7_i,
  output logic                phase_o,
  output logic [WIDE_W-1:0]   s9_q_o,
  output logic [NARROW_W-1:0] s7_q_o,
  output logic                s9_upd_o,
  output logic                s7_upd_o
);
  logic                rst_sync_n;
  phase_e              phase_q, phase_d;
  logic [WIDE_W-1:0]   w;
  logic [PAIR_N-1:0]   prod;
  logic [WIDE_W-1:0]   res;
  logic [WIDE_W-1:0]   s9_q, s9_d;
  logic [NARROW_W-1:0] s7_q, s7_d;
  logic                s9_en, s7_en;
  logic                s9_upd_q, s7_upd_q;

  subst_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .rst_sync_n_o(rst_sync_n)
  );

  subst_operand_mux opmux_i (
    .phase_i(phase_q), .op9_i(op9_i), .op7_i(op7_i), .w_o(w)
  );

  subst_term_gen terms_i (.w_i(w), .prod_o(prod));

  subst_xor_net net_i (
    .phase_i(phase_q), .w_i(w), .prod_i(prod), .res_o(res)
  );

  always_comb begin
    s9_en   = step_i && (phase_q == PH_WIDE);
    s7_en   = step_i && (phase_q == PH_NARROW);
    phase_d = step_i ? ((phase_q == PH_WIDE) ? PH_NARROW : PH_WIDE) : phase_q;
    s9_d    = res;
    s7_d    = res[NARROW_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q  <= PH_WIDE;
      s9_q     <= '0;
      s7_q     <= '0;
      s9_upd_q <= 1'b0;
      s7_upd_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      if (s9_en) s9_q <= s9_d;
      if (s7_en) s7_q <= s7_d;
      s9_upd_q <= s9_en;
      s7_upd_q <= s7_en;
    end
  end

  assign phase_o  = phase_q;
  assign s9_q_o   = s9_q;
  assign s7_q_o   = s7_q;
  assign s9_upd_o = s9_upd_q;
  assign s7_upd_o = s7_upd_q;
endmodule

// File: rtl/sbox_duo_chk.sv
module sbox_duo_chk
  import subst_pkg::*;
(
  input logic                clk_i,
  input logic                rst_n_i,
  input logic                step_i,
  input logic                phase_i,
  input logic [WIDE_W-1:0]   s9_i,
  input logic [NARROW_W-1:0] s7_i,
  input logic                s9_upd_i,
  input logic                s7_upd_i
);
  p_phase_flip_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    step_i |=> (phase_i != $past(phase_i)));
  p_s9_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (step_i && !phase_i) |=> s9_upd_i);
  p_s7_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (step_i && phase_i) |=> s7_upd_i);
  p_s9_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (step_i && phase_i) |=> $stable(s9_i));
  p_s7_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (step_i && !phase_i) |=> $stable(s7_i));
  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !step_i |=> ($stable(phase_i) && $stable(s9_i) && $stable(s7_i) && !s9_upd_i && !s7_upd_i));
  p_flag_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0({s9_upd_i, s7_upd_i}));
endmodule

bind sbox_duo sbox_duo_chk chk_i (
  .clk_i(clk_i), .rst_n_i(rst_sync_n), .step_i(step_i), .phase_i(phase_o),
  .s9_i(s9_q_o), .s7_i(s7_q_o), .s9_upd_i(s9_upd_o), .s7_upd_i(s7_upd_o)
);

// File: tb/sbox_duo_tb.sv
module sbox_duo_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       step;
  logic [8:0] op9;
  logic [6:0] op7;
  logic       phase;
  logic [8:0] s9q;
  logic [6:0] s7q;
  logic       s9u, s7u;
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sbox_duo dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .step_i(step), .op9_i(op9), .op7_i(op7),
    .phase_o(phase), .s9_q_o(s9q), .s7_q_o(s7q), .s9_upd_o(s9u), .s7_upd_o(s7u)
  );

  // {op9, exp9, op7, exp7}
  localparam logic [31:0] VEC [7] = '{
    {9'd0, 9'd451, 7'd0, 7'd27}, {9'd1, 9'd203, 7'd1, 7'd50},
    {9'd2, 9'd339, 7'd2, 7'd51}, {9'd3, 9'd415, 7'd3, 7'd90},
    {9'd4, 9'd483, 7'd4, 7'd59}, {9'd0, 9'd451, 7'd5, 7'd16},
    {9'd1, 9'd203, 7'd6, 7'd23}
  };

  function automatic logic [8:0] ref9(input logic [8:0] x);
    logic [8:0] y;
    y[0] = x[0]&x[4] ^ x[0]&x[5] ^ x[1]&x[5] ^ x[1]&x[6] ^ x[2]&x[6] ^ x[2]&x[7] ^ x[3]&x[7] ^ x[3]&x[8] ^ x[4]&x[8] ^ 1'b1;
    y[1] = x[0]&x[2] ^ x[3] ^ x[1]&x[3] ^ x[2]&x[3] ^ x[3]&x[4] ^ x[4]&x[5] ^ x[0]&x[6] ^ x[2]&x[6] ^ x[7] ^ x[0]&x[8] ^ x[3]&x[8] ^ x[5]&x[8] ^ 1'b1;
    y[2] = x[0]&x[1] ^ x[1]&x[3] ^ x[4] ^ x[0]&x[4] ^ x[2]&x[4] ^ x[3]&x[4] ^ x[4]&x[5] ^ x[0]&x[6] ^ x[5]&x[6] ^ x[1]&x[7] ^ x[3]&x[7] ^ x[8];
    y[3] = x[0] ^ x[1]&x[2] ^ x[2]&x[4] ^ x[5] ^ x[1]&x[5] ^ x[3]&x[5] ^ x[4]&x[5] ^ x[5]&x[6] ^ x[1]&x[7] ^ x[6]&x[7] ^ x[2]&x[8] ^ x[4]&x[8];
    y[4] = x[1] ^ x[0]&x[3] ^ x[2]&x[3] ^ x[0]&x[5] ^ x[3]&x[5] ^ x[6] ^ x[2]&x[6] ^ x[4]&x[6] ^ x[5]&x[6] ^ x[6]&x[7] ^ x[2]&x[8] ^ x[7]&x[8];
    y[5] = x[2] ^ x[0]&x[3] ^ x[1]&x[4] ^ x[3]&x[4] ^ x[1]&x[6] ^ x[4]&x[6] ^ x[7] ^ x[3]&x[7] ^ x[5]&x[7] ^ x[6]&x[7] ^ x[0]&x[8] ^ x[7]&x[8];
    y[6] = x[0]&x[1] ^ x[3] ^ x[1]&x[4] ^ x[2]&x[5] ^ x[4]&x[5] ^ x[2]&x[7] ^ x[5]&x[7] ^ x[8] ^ x[0]&x[8] ^ x[4]&x[8] ^ x[6]&x[8] ^ x[7]&x[8] ^ 1'b1;
    y[7] = x[1] ^ x[0]&x[1] ^ x[1]&x[2] ^ x[2]&x[3] ^ x[0]&x[4] ^ x[5] ^ x[1]&x[6] ^ x[3]&x[6] ^ x[0]&x[7] ^ x[4]&x[7] ^ x[6]&x[7] ^ x[1]&x[8] ^ 1'b1;
    y[8] = x[0] ^ x[0]&x[1] ^ x[1]&x[2] ^ x[4] ^ x[0]&x[5] ^ x[2]&x[5] ^ x[3]&x[6] ^ x[5]&x[6] ^ x[0]&x[7] ^ x[0]&x[8] ^ x[3]&x[8] ^ x[6]&x[8] ^ 1'b1;
    return y;
  endfunction

  function automatic logic [6:0] ref7(input logic [6:0] x);
    logic [6:0] y;
    y[0] = x[0] ^ x[1]&x[3] ^ x[0]&x[3]&x[4] ^ x[1]&x[5] ^ x[0]&x[2]&x[5] ^ x[4]&x[5] ^ x[0]&x[1]&x[6] ^ x[2]&x[6] ^ x[0]&x[5]&x[6] ^ x[3]&x[5]&x[6] ^ 1'b1;
    y[1] = x[0]&x[2] ^ x[0]&x[4] ^ x[3]&x[4] ^ x[1]&x[5] ^ x[2]&x[4]&x[5] ^ x[6] ^ x[0]&x[6] ^ x[3]&x[6] ^ x[2]&x[3]&x[6] ^ x[1]&x[4]&x[6] ^ x[0]&x[5]&x[6] ^ 1'b1;
    y[2] = x[1]&x[2] ^ x[0]&x[2]&x[3] ^ x[4] ^ x[1]&x[4] ^ x[0]&x[1]&x[4] ^ x[0]&x[5] ^ x[0]&x[4]&x[5] ^ x[3]&x[5] ^ x[1]&x[3]&x[5] ^ x[6] ^ x[0]&x[2]&x[6] ^ x[1]&x[6] ^ x[4]&x[5]&x[6];
    y[3] = x[0] ^ x[1] ^ x[0]&x[1]&x[2] ^ x[0]&x[3] ^ x[2]&x[4] ^ x[1]&x[4]&x[5] ^ x[2]&x[6] ^ x[1]&x[3]&x[6] ^ x[0]&x[4]&x[6] ^ x[5]&x[6] ^ 1'b1;
    y[4] = x[2]&x[3] ^ x[0]&x[4] ^ x[1]&x[3]&x[4] ^ x[5] ^ x[2]&x[5] ^ x[1]&x[2]&x[5] ^ x[0]&x[3]&x[5] ^ x[1]&x[6] ^ x[1]&x[5]&x[6] ^ x[4]&x[5]&x[6] ^ 1'b1;
    y[5] = x[0] ^ x[1] ^ x[2] ^ x[0]&x[1]&x[2] ^ x[0]&x[3] ^ x[1]&x[2]&x[3] ^ x[1]&x[4] ^ x[0]&x[2]&x[4] ^ x[0]&x[5] ^ x[0]&x[1]&x[5] ^ x[3]&x[5] ^ x[0]&x[6] ^ x[2]&x[5]&x[6];
    y[6] = x[0]&x[1] ^ x[3] ^ x[0]&x[3] ^ x[2]&x[3]&x[4] ^ x[0]&x[5] ^ x[2]&x[5] ^ x[3]&x[5] ^ x[1]&x[3]&x[5] ^ x[1]&x[6] ^ x[1]&x[2]&x[6] ^ x[0]&x[3]&x[6] ^ x[4]&x[6] ^ x[2]&x[5]&x[6];
    return y;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one 9-bit step then one 7-bit step; idle operand carries inverted data
  task automatic pair(input logic [8:0] a9, input logic [8:0] e9,
                      input logic [6:0] a7, input logic [6:0] e7);
    logic [6:0] s7_before;
    s7_before = s7q;
    step = 1'b1; op9 = a9; op7 = ~a7;
    @(negedge clk);
    chk(s9q == e9, "R8 s9 result", s9q, e9);
    chk(s9u && !s7u, "R2 s9 flag", {s9u, s7u}, 2);
    chk(phase == 1'b1, "R2 phase to 1", phase, 1);
    chk(s7q == s7_before, "R4 s7 held", s7q, s7_before);
    op7 = a7; op9 = ~a9;
    @(negedge clk);
    chk(s7q == e7, "R9 s7 result", s7q, e7);
    chk(!s9u && s7u, "R3 s7 flag", {s9u, s7u}, 1);
    chk(phase == 1'b0, "R3 phase to 0", phase, 0);
    chk(s9q == e9, "R6 op9 ignored in 7-bit step", s9q, e9);
    step = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; step = 1'b0; op9 = '0; op7 = '0;
    repeat (3) @(negedge clk);
    chk(phase == 1'b0 && s9q == 0 && s7q == 0, "R1 reset state", {phase, s9q, s7q}, 0);
    chk(!s9u && !s7u, "R1 flags low", {s9u, s7u}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(phase == 1'b0 && s9q == 0 && s7q == 0 && !s9u && !s7u, "R1 after release",
        {phase, s9q, s7q}, 0);

    // table of directed vectors (R8, R9)
    foreach (VEC[i]) pair(VEC[i][31:23], VEC[i][22:14], VEC[i][13:7], VEC[i][6:0]);

    // exhaustive sweep: 512 nine-bit inputs, 128 seven-bit inputs (R8, R9)
    for (int k = 0; k < 512; k++) pair(9'(k), ref9(9'(k)), 7'(k), ref7(7'(k)));

    // idle cycles with moving operands (R5)
    begin
      logic [8:0] h9; logic [6:0] h7; logic hp;
      @(negedge clk);
      h9 = s9q; h7 = s7q; hp = phase;
      for (int k = 0; k < 4; k++) begin
        op9 = 9'(k * 77); op7 = 7'(k * 13);
        @(negedge clk);
        chk(s9q == h9 && s7q == h7 && phase == hp, "R5 idle hold", {phase, s9q, s7q}, {hp, h9, h7});
        chk(!s9u && !s7u, "R5 flags low when idle", {s9u, s7u}, 0);
      end
    end

    // one 9-bit step then idle: phase parks at 1, flag drops (R2, R5, R7)
    step = 1'b1; op9 = 9'd4; op7 = 7'd0;
    @(negedge clk);
    step = 1'b0;
    chk(s9q == 9'd483 && phase == 1'b1, "R2 single step", s9q, 483);
    @(negedge clk);
    chk(!s9u && !s7u && phase == 1'b1, "R7 flag one cycle", {s9u, s7u}, 0);

    // mid-run reset clears everything at once (R1)
    rst_n = 1'b0;
    #1;
    chk(phase == 1'b0 && s9q == 0 && s7q == 0 && !s9u && !s7u, "R1 async reset",
        {phase, s9q, s7q}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(phase == 1'b0 && s9q == 0 && s7q == 0, "R1 second release", {phase, s9q, s7q}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule